// File: doc/BRIEF.md
# Oscillator Clock Controller with Periodic Time Base

This block derives the processor's clock rate and a periodic time reference from a single oscillator clock. A free-running time-base counter counts oscillator cycles over one of four programmable periods. At the end of each period it sets a status flag. Software clears the flag by reading the status/control register. When the interrupt enable is set, the flag drives both an interrupt request and a wakeup request, so the periodic event can bring the processor out of an active low-power halt. The counter never stops, so it runs through that halt.

The processor clock comes out as a one-cycle clock-enable pulse, not as a derived clock. In normal mode the pulse is high on every oscillator cycle. In slow mode it fires once every 2, 4, 8 or 16 cycles.

A new period selection never shortens or stretches the period already in progress, so the time base stays usable as a real-time clock. A divider change also takes effect only at the next enable pulse.

Top module: `clkctl_tbase`

## Requirements
- R1: After reset, every control bit and the flag read as 0 (rd_data == 0), irq and wake are 0, cpu_ce is high every cycle, and the first flag appears TB_P0 cycles after reset.
- R2: The period is set by the field wr_data[2:1]. The value 00 selects TB_P0 cycles, 01 selects TB_P1, 10 selects TB_P2 and 11 selects TB_P3. The defaults are 16000, 32000, 80000 and 200000.
- R3: A write to the period field lets the running period finish at its old length. The new length applies from the following period.
- R4: The flag, read at rd_data[0], is set at the end of every period, whether or not it was read in the meantime.
- R5: A cycle with rd_en high returns the current flag on rd_data[0] and clears the flag on the next clock edge.
- R6: When a period ends in the same cycle as a read, the flag is 1 after that edge.
- R7: irq is high exactly when the flag is 1 and the enable bit wr_data[0] (read back at rd_data[1]) is 1. With the enable at 0, irq stays low.
- R8: wake follows irq on every cycle.
- R9: With the slow bit wr_data[3] at 0, cpu_ce is high on every cycle.
- R10: With the slow bit at 1, cpu_ce pulses once every 2^(d+1) cycles, where d is the field wr_data[5:4].
- R11: A change to the slow bit or the divider field takes effect at the next cpu_ce pulse. The interval already in progress completes at its old length.
- R12: rd_data[6:1] reads back the last value written to wr_data[5:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 6 | Control value: [0] irq enable, [2:1] period select, [3] slow, [5:4] divider |
| rd_en | input | 1 | Status/control read strobe; clears the flag |
| rd_data | output | 7 | {control[5:0], flag} |
| cpu_ce | output | 1 | Processor clock-enable pulse |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request out of active halt |

## Verification
The bench writes a new period mid-period and checks that the next interval still has the old length. A design that applied the selection at once would produce a short or shifted period there. It lands a status read on the exact cycle a period ends. A design that gave priority to the clear would lose that event and show the flag low. A divider change is made in the middle of a slow interval. A design that reloaded at once would emit an early or late pulse. Reset and the first period are measured from reset release, so an off-by-one in the terminal count shows up as a wrong interval.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int CTRL_W = 6;
    localparam int DIV_W  = 2;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             slow;
        logic [SEL_W-1:0] tb_sel;
        logic             irq_en;
    } ctrl_t;
endpackage

// File: rtl/clkctl_tb_cnt.sv
module clkctl_tb_cnt #(
    parameter int TB_P0 = 16000,
    parameter int TB_P1 = 32000,
    parameter int TB_P2 = 80000,
    parameter int TB_P3 = 200000,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_req,
    output logic             tick,
    output logic [SEL_W-1:0] act_sel
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int MAX01 = (TB_P0 > TB_P1) ? TB_P0 : TB_P1;
    localparam int MAX23 = (TB_P2 > TB_P3) ? TB_P2 : TB_P3;
    localparam int PMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(PMAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] last_tab [NSEL];

    // Terminal values, one per selection.
    for (genvar g = 0; g < NSEL; g++) begin : g_last
        localparam int PER = (g % 4 == 0) ? TB_P0 :
                             (g % 4 == 1) ? TB_P1 :
                             (g % 4 == 2) ? TB_P2 : TB_P3;
        assign last_tab[g] = CNT_W'(PER - 1);
    end

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == last_tab[st_q.sel]);
        if (tick) begin
            st_d.cnt = '0;
            st_d.sel = sel_req;   // new length only from the next period
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_sel = st_q.sel;
endmodule

// File: rtl/clkctl_ce_gen.sv
module clkctl_ce_gen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_req,
    input  logic [DIV_W-1:0] div_req,
    output logic             ce
);
    localparam int CNT_W = 1 << DIV_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             slow;
        logic [DIV_W-1:0] div;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        st_d = st_q;
        term = CNT_W'((32'd1 << (32'(st_q.div) + 32'd1)) - 32'd1);
        ce   = !st_q.slow || (st_q.cnt == term);
        if (ce) begin
            st_d.cnt  = '0;
            st_d.slow = slow_req;   // settings resync at each pulse
            st_d.div  = div_req;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/clkctl_tbase.sv
module clkctl_tbase
    import clkctl_pkg::*;
#(
    parameter int TB_P0 = 16000,
    parameter int TB_P1 = 32000,
    parameter int TB_P2 = 80000,
    parameter int TB_P3 = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CTRL_W:0]   rd_data,
    output logic              cpu_ce,
    output logic              irq,
    output logic              wake
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
    } st_t;

    st_t st_d, st_q;
    logic             tb_tick;
    logic [SEL_W-1:0] act_sel;

    clkctl_tb_cnt #(
        .TB_P0(TB_P0), .TB_P1(TB_P1), .TB_P2(TB_P2), .TB_P3(TB_P3), .SEL_W(SEL_W)
    ) u_tbcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_req (st_q.ctrl.tb_sel),
        .tick    (tb_tick),
        .act_sel (act_sel)
    );

    clkctl_ce_gen #(.DIV_W(DIV_W)) u_cegen (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_req (st_q.ctrl.slow),
        .div_req  (st_q.ctrl.div),
        .ce       (cpu_ce)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctrl = ctrl_t'(wr_data);
        // a period end beats a read-clear in the same cycle
        st_d.flag = tb_tick | (st_q.flag & ~rd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = {st_q.ctrl, st_q.flag};
    assign irq     = st_q.flag & st_q.ctrl.irq_en;
    assign wake    = irq;
endmodule

// File: rtl/clkctl_tbase_chk.sv
module clkctl_tbase_chk
    import clkctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              tick,
    input logic              flag,
    input logic [SEL_W-1:0]  act_sel,
    input logic              slow_prog,
    input logic [CTRL_W:0]   rd_data,
    input logic              cpu_ce,
    input logic              irq,
    input logic              wake
);
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag);

    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !tick) |=> !flag);

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_en) |=> flag);

    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(act_sel));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[0] && rd_data[1]));

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);

    p_slow_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && slow_prog) |=> !cpu_ce);
endmodule

bind clkctl_tbase clkctl_tbase_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .tick      (tb_tick),
    .flag      (st_q.flag),
    .act_sel   (act_sel),
    .slow_prog (st_q.ctrl.slow),
    .rd_data   (rd_data),
    .cpu_ce    (cpu_ce),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/clkctl_tbase_tb.sv
module clkctl_tbase_tb;
    localparam int P0 = 16, P1 = 32, P2 = 80, P3 = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [6:0] rd_data;
    logic       cpu_ce, irq, wake;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clkctl_tbase #(.TB_P0(P0), .TB_P1(P1), .TB_P2(P2), .TB_P3(P3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cpu_ce(cpu_ce), .irq(irq), .wake(wake)
    );

    // stimulus vectors: {div, slow, tb_sel, irq_en}
    localparam logic [5:0] VEC [8] = '{
        6'b00_0_01_1, 6'b00_1_10_0, 6'b01_1_11_1, 6'b10_1_00_0,
        6'b11_1_01_1, 6'b11_0_10_1, 6'b01_1_00_0, 6'b10_1_11_1
    };

    function automatic int tb_len(input logic [1:0] s);
        case (s)
            2'd0: return P0;
            2'd1: return P1;
            2'd2: return P2;
            default: return P3;
        endcase
    endfunction

    function automatic int ce_len(input logic slow, input logic [1:0] d);
        return slow ? (2 << d) : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sync_flag();
        while (!rd_data[0]) @(negedge clk);
    endtask

    // called at a negedge where the flag is high: clears it, returns cycles to next rise
    task automatic measure(output int n);
        rd_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            rd_en = 1'b0;
            wr_en = 1'b0;
            n++;
        end while (!rd_data[0]);
    endtask

    task automatic ce_interval(output int n);
        while (!cpu_ce) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wake", int'(wake), 0);
        chk("R1 cpu_ce", int'(cpu_ce), 1);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk("R9 cpu_ce normal", int'(cpu_ce), 1);
        end while (!rd_data[0]);
        chk("R1 first period", n, P0);

        // table walk
        foreach (VEC[i]) begin
            logic [5:0] v;
            v = VEC[i];
            sync_flag();
            wr_en = 1'b1;
            wr_data = v;
            measure(n);               // old period finishes (R3)
            measure(n);
            chk("R2 period", n, tb_len(v[2:1]));
            chk("R12 readback", int'(rd_data[6:1]), int'(v));
            chk("R7 irq", int'(irq), int'(v[0]));
            chk("R8 wake", int'(wake), int'(irq));
            ce_interval(n);
            ce_interval(n);
            chk(v[3] ? "R10 ce interval" : "R9 ce interval", n, ce_len(v[3], v[5:4]));
        end

        // R3: mid-period change keeps the running period length
        sync_flag();
        wr_en = 1'b1; wr_data = 6'b00_0_00_1;
        measure(n);
        measure(n);
        chk("R3 settle P0", n, P0);
        wr_en = 1'b1; wr_data = 6'b00_0_10_1;
        measure(n);
        chk("R3 old length kept", n, P0);
        measure(n);
        chk("R3 new length applied", n, P2);

        // R4: flag keeps rising each period without reads
        wr_en = 1'b1; wr_data = 6'b00_0_00_0;
        measure(n);                   // P2 finishes
        measure(n);
        chk("R4 period P0", n, P0);
        repeat (2 * P0) @(negedge clk);
        chk("R4 flag set", int'(rd_data[0]), 1);
        chk("R7 irq disabled", int'(irq), 0);

        // R5 and R6: read clears, but not when it meets a period end
        sync_flag();
        // flag first seen now; next end is P0 negedges away
        rd_en = 1'b1;
        chk("R5 read returns flag", int'(rd_data[0]), 1);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R5 flag cleared", int'(rd_data[0]), 0);
        repeat (P0 - 2) @(negedge clk);
        rd_en = 1'b1;
        chk("R6 flag low before clash", int'(rd_data[0]), 0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6 flag kept on clash", int'(rd_data[0]), 1);

        // R11: divider change applies at the next pulse
        wr_en = 1'b1; wr_data = 6'b11_1_00_0;
        @(negedge clk);
        wr_en = 1'b0;
        ce_interval(n);
        ce_interval(n);
        chk("R11 settle /16", n, 16);
        while (!cpu_ce) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) begin wr_en = 1'b1; wr_data = 6'b00_1_00_0; end
            if (n == 4) wr_en = 1'b0;
        end while (!cpu_ce);
        chk("R11 old interval kept", n, 16);
        ce_interval(n);
        chk("R11 new interval", n, 2);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule